// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the fetch address and answers, within the same cycle, whether a branch at that address was seen before. If it was, the block returns the remembered destination and a taken or not-taken guess from a 2-bit saturating counter. Entries live in a set-associative array of tag, target and counter fields. An address that finds no matching entry is always guessed not taken.

A separate resolve port carries finished branches back from execution: the branch address, the real direction and the real destination. A resolve that matches an entry moves that entry's counter toward the real outcome. A resolve that matches nothing writes a fresh entry. The way it overwrites is chosen by the low bits of a free-running linear-feedback shift register, so the choice is pseudo-random but repeatable after reset.

Top module: `btb_predictor`

## Requirements
- R1: While reset is held and after reset is released, every entry is empty, so every lookup reports no hit, not taken and a zero target until a resolve writes an entry.
- R2: A lookup that matches no entry drives hit low, taken low and target zero.
- R3: With defaults (32-bit addresses, 256 entries, 4 ways, 2 alignment bits), the set index is address bits [7:2] and the tag is bits [31:8]. A lookup hits only when a valid way of that set holds the same tag.
- R4: Lookup outputs are combinational from the lookup address in the same cycle. When a resolve writes the looked-up entry in that cycle, the lookup shows the contents from before that write.
- R5: A valid resolve that misses fills way lfsr[1:0] of its set with the tag, the resolved target and counter 2 if taken or 1 if not taken. The entry is visible to lookups from the next cycle.
- R6: A valid resolve that hits adds 1 to the counter when taken, saturating at 3, and subtracts 1 when not taken, saturating at 0. It replaces the stored target only when taken.
- R7: A hitting lookup predicts taken exactly when the counter is 2 or 3, and its target output is the stored target.
- R8: The 8-bit replacement register resets to 0x01 and on every clock after reset becomes {q[6:0], q[7]^q[5]^q[4]^q[3]}. The victim is taken from the value held before the edge.
- R9: A resolve with its valid input low changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | 32 | Fetch address looked up |
| lk_hit_o | output | 1 | Lookup matched an entry |
| lk_taken_o | output | 1 | Predicted direction |
| lk_target_o | output | 32 | Predicted destination |
| rs_valid_i | input | 1 | Resolve port carries a branch this cycle |
| rs_pc_i | input | 32 | Address of the resolved branch |
| rs_taken_i | input | 1 | Actual direction |
| rs_target_i | input | 32 | Actual destination |

## Verification
Lookup results are due in the same cycle as the address, so the bench drives inputs on the falling edge and samples one time unit later, before the rising edge. Resolve effects are due one rising edge later. The bench's reference model applies each resolve, and steps its own copy of the replacement register, on that rising edge. A lookup in the cycle of the resolve is therefore compared against the old contents, and a lookup in the following cycle against the new ones.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_WEAK_T  = 2'd2;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btb_lfsr.sv
module btb_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= SEED;
    else         q_q <= {q_q[W-2:0], ^(q_q & TAPS)};
  end

  assign q_o = q_q;

  a_r8_never_stuck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);
endmodule

// File: rtl/btb_way.sv
module btb_way
  import btb_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_valid_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [ADDR_W-1:0] lk_tgt_o,
  output ctr_t              lk_ctr_o,
  input  logic [IDX_W-1:0]  rs_idx_i,
  output logic              rs_valid_o,
  output logic [TAG_W-1:0]  rs_tag_o,
  output logic [ADDR_W-1:0] rs_tgt_o,
  output ctr_t              rs_ctr_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  ctr_t              wr_ctr_i
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [ADDR_W-1:0] tgt_q [SETS];
  ctr_t              ctr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tgt_q[wr_idx_i] <= wr_tgt_i;
      ctr_q[wr_idx_i] <= wr_ctr_i;
    end
  end

  assign lk_valid_o = valid_q[lk_idx_i];
  assign lk_tag_o   = tag_q[lk_idx_i];
  assign lk_tgt_o   = tgt_q[lk_idx_i];
  assign lk_ctr_o   = ctr_q[lk_idx_i];
  assign rs_valid_o = valid_q[rs_idx_i];
  assign rs_tag_o   = tag_q[rs_idx_i];
  assign rs_tgt_o   = tgt_q[rs_idx_i];
  assign rs_ctr_o   = ctr_q[rs_idx_i];

  // R5 / R6: a write is retained and readable at the next edge
  a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)] && ctr_q[$past(wr_idx_i)] == $past(wr_ctr_i)
                && tgt_q[$past(wr_idx_i)] == $past(wr_tgt_i));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int WAYS    = 4,
  parameter int ALIGN_W = 2,
  parameter int LFSR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              rs_valid_i,
  input  logic [ADDR_W-1:0] rs_pc_i,
  input  logic              rs_taken_i,
  input  logic [ADDR_W-1:0] rs_target_i
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  assign lk_idx = lk_pc_i[ALIGN_W +: IDX_W];
  assign rs_idx = rs_pc_i[ALIGN_W +: IDX_W];
  assign lk_tag = lk_pc_i[ADDR_W-1 -: TAG_W];
  assign rs_tag = rs_pc_i[ADDR_W-1 -: TAG_W];

  logic [LFSR_W-1:0] lfsr_q;
  btb_lfsr #(.W(LFSR_W)) u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .q_o(lfsr_q));

  logic [WAY_W-1:0] victim;
  assign victim = lfsr_q[WAY_W-1:0];

  logic              lk_v   [WAYS];
  logic [TAG_W-1:0]  lk_t   [WAYS];
  logic [ADDR_W-1:0] lk_tg  [WAYS];
  ctr_t              lk_c   [WAYS];
  logic              rs_v   [WAYS];
  logic [TAG_W-1:0]  rs_t   [WAYS];
  logic [ADDR_W-1:0] rs_tg  [WAYS];
  ctr_t              rs_c   [WAYS];
  logic [WAYS-1:0]   lk_hit, rs_hit, wr_en;

  logic [ADDR_W-1:0] wr_tgt;
  ctr_t              wr_ctr;
  logic              rs_any;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    btb_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_way (
      .clk_i, .rst_ni,
      .lk_idx_i(lk_idx), .lk_valid_o(lk_v[w]), .lk_tag_o(lk_t[w]),
      .lk_tgt_o(lk_tg[w]), .lk_ctr_o(lk_c[w]),
      .rs_idx_i(rs_idx), .rs_valid_o(rs_v[w]), .rs_tag_o(rs_t[w]),
      .rs_tgt_o(rs_tg[w]), .rs_ctr_o(rs_c[w]),
      .wr_en_i(wr_en[w]), .wr_idx_i(rs_idx), .wr_tag_i(rs_tag),
      .wr_tgt_i(wr_tgt), .wr_ctr_i(wr_ctr)
    );
    assign lk_hit[w] = lk_v[w] && (lk_t[w] == lk_tag);
    assign rs_hit[w] = rs_v[w] && (rs_t[w] == rs_tag);
    assign wr_en[w]  = rs_valid_i && (rs_any ? rs_hit[w] : (victim == WAY_W'(w)));
  end

  assign rs_any = |rs_hit;

  // lookup mux, lowest way wins
  always_comb begin
    lk_hit_o    = 1'b0;
    lk_taken_o  = 1'b0;
    lk_target_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hit[w]) begin
        lk_hit_o    = 1'b1;
        lk_taken_o  = lk_c[w][1];
        lk_target_o = lk_tg[w];
      end
    end
  end

  // resolve write data
  always_comb begin
    logic [ADDR_W-1:0] old_tgt;
    ctr_t              old_ctr;
    old_tgt = '0;
    old_ctr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rs_hit[w]) begin
        old_tgt = rs_tg[w];
        old_ctr = rs_c[w];
      end
    end
    if (rs_any) begin
      wr_ctr = ctr_step(old_ctr, rs_taken_i);
      wr_tgt = rs_taken_i ? rs_target_i : old_tgt;
    end else begin
      wr_ctr = rs_taken_i ? CTR_WEAK_T : CTR_WEAK_NT;
      wr_tgt = rs_target_i;
    end
  end

  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit));
  a_r5_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  a_r9_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_valid_i |-> wr_en == '0);
  a_r2_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> !lk_taken_o && lk_target_o == '0);
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc, rs_pc, rs_tgt, lk_target;
  logic        lk_hit, lk_taken, rs_valid, rs_taken;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  btb_predictor uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pc_i(lk_pc), .lk_hit_o(lk_hit), .lk_taken_o(lk_taken), .lk_target_o(lk_target),
    .rs_valid_i(rs_valid), .rs_pc_i(rs_pc), .rs_taken_i(rs_taken), .rs_target_i(rs_tgt)
  );

  // reference model
  bit          m_v   [4][64];
  logic [23:0] m_tag [4][64];
  logic [31:0] m_tg  [4][64];
  logic [1:0]  m_ctr [4][64];
  logic [7:0]  m_lfsr;

  always @(posedge clk or negedge rst_n) begin : model
    int idx, hw;
    logic [23:0] tg;
    if (!rst_n) begin
      for (int w = 0; w < 4; w++) for (int s = 0; s < 64; s++) m_v[w][s] = 1'b0;
      m_lfsr = 8'h01;
    end else begin
      if (rs_valid) begin
        idx = int'(rs_pc[7:2]);
        tg  = rs_pc[31:8];
        hw  = -1;
        for (int w = 0; w < 4; w++) if (hw < 0 && m_v[w][idx] && m_tag[w][idx] == tg) hw = w;
        if (hw >= 0) begin
          if (rs_taken) begin
            if (m_ctr[hw][idx] != 2'd3) m_ctr[hw][idx] = m_ctr[hw][idx] + 2'd1;
            m_tg[hw][idx] = rs_tgt;
          end else if (m_ctr[hw][idx] != 2'd0) m_ctr[hw][idx] = m_ctr[hw][idx] - 2'd1;
        end else begin
          hw = int'(m_lfsr[1:0]);
          m_v[hw][idx]   = 1'b1;
          m_tag[hw][idx] = tg;
          m_tg[hw][idx]  = rs_tgt;
          m_ctr[hw][idx] = rs_taken ? 2'd2 : 2'd1;
        end
      end
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic look_check(string req);
    int idx;
    logic eh, et;
    logic [31:0] eg;
    idx = int'(lk_pc[7:2]);
    eh = 1'b0; et = 1'b0; eg = '0;
    for (int w = 3; w >= 0; w--) begin
      if (m_v[w][idx] && m_tag[w][idx] == lk_pc[31:8]) begin
        eh = 1'b1; et = m_ctr[w][idx][1]; eg = m_tg[w][idx];
      end
    end
    check(req, "hit", 32'(lk_hit), 32'(eh));
    check(req, "taken", 32'(lk_taken), 32'(et));
    check(req, "target", lk_target, eg);
  endtask

  task automatic cyc(string req, logic [31:0] lpc, logic rv, logic [31:0] rpc,
                     logic rt, logic [31:0] rg);
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_tgt = rg;
    #1;
    look_check(req);
  endtask

  function automatic logic [31:0] mkpc(int tag, int idx);
    return {24'(tag), 6'(idx), 2'b00};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rs_valid = 1'b0; lk_pc = mkpc(1, 3); rs_pc = '0; rs_taken = 1'b0; rs_tgt = '0;
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1", "hit in reset", 32'(lk_hit), 32'd0);
    check("R1", "target in reset", lk_target, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R1", mkpc(i, i), 1'b0, '0, 1'b0, '0);

    // R4: same-cycle lookup sees old state, R5 next cycle
    cyc("R4", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b1, 32'h1000_0040);
    cyc("R5", mkpc(7, 20), 1'b0, '0, 1'b0, '0);
    // R3: same index, different tag misses; same tag other index misses
    cyc("R3", mkpc(8, 20), 1'b0, '0, 1'b0, '0);
    cyc("R3", mkpc(7, 21), 1'b0, '0, 1'b0, '0);

    // R6 saturation up, then down, with target kept on not-taken
    for (int i = 0; i < 4; i++) cyc("R6", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b1, 32'h1000_0080);
    cyc("R6", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b0, 32'hDEAD_0000);
    cyc("R7", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b0, 32'hDEAD_0000);
    cyc("R7", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b0, 32'hDEAD_0000);
    for (int i = 0; i < 3; i++) cyc("R6", mkpc(7, 20), 1'b1, mkpc(7, 20), 1'b0, 32'h0);
    cyc("R6", mkpc(7, 20), 1'b0, '0, 1'b0, '0);

    // R5: not-taken allocation starts weakly not taken
    cyc("R5", mkpc(9, 22), 1'b1, mkpc(9, 22), 1'b0, 32'h2222_0000);
    cyc("R5", mkpc(9, 22), 1'b0, '0, 1'b0, '0);

    // R9: idle resolve ignored
    cyc("R9", mkpc(3, 30), 1'b0, mkpc(3, 30), 1'b1, 32'h3333_0000);
    cyc("R9", mkpc(3, 30), 1'b0, '0, 1'b0, '0);

    // R8: overfill one set, evictions follow the replacement register
    for (int t = 0; t < 8; t++) cyc("R8", mkpc(t, 40), 1'b1, mkpc(100 + t, 40), 1'b1, 32'(t * 16));
    for (int t = 0; t < 8; t++) cyc("R8", mkpc(100 + t, 40), 1'b0, '0, 1'b0, '0);

    // R7: random traffic on a small address pool
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lp, rp;
      lp = mkpc(int'($urandom_range(0, 5)), int'($urandom_range(8, 11)));
      rp = mkpc(int'($urandom_range(0, 5)), int'($urandom_range(8, 11)));
      cyc("R7", lp, 1'($urandom_range(0, 1)), rp, 1'($urandom_range(0, 1)),
          {$urandom_range(0, 255), 2'b00});
    end
    finish_run();
  end
endmodule